// File: doc/BRIEF.md
# Amplitude-keyed sine sample generator

This block produces the sample words for an external 12-bit parallel DAC that carries a time code as an amplitude-keyed sine wave. It holds one cycle of a sine carrier at two amplitudes, a strong one and a weak one, in a 10:3 ratio. Each time the sample-rate enable is asserted it emits the next point of the cycle. With a 1 MHz enable a cycle of 1000 points gives a 1 kHz carrier, so a 10 ms code symbol spans ten carrier cycles.

The baseband level from the frame generator picks the amplitude. The level is looked at only at the first point of each carrier cycle, so amplitude steps happen only where the wave crosses mid-scale. A symbol whose baseband pulse lasts 2, 5 or 8 ms therefore shows as 2, 5 or 8 strong carrier cycles, followed by weak cycles up to ten. The sine values are computed when the design is elaborated. Only a quarter of the wave is stored per amplitude, and the other three quarters are derived from it.

The output is a registered sample with a one-cycle write strobe that acts as the valid flag of a stream with no ready. A DAC cannot stall, so there is no back-pressure. The sink must take the word in every cycle where the strobe is high. The word stays put until the next strobe.

Top module: `amp_keyed_sine_gen`

## Requirements
- R1: A synchronous reset drives `sample_out` to mid-scale 2048 and `dac_wr` low, sets the carrier phase to 0 and selects the weak amplitude.
- R2: The phase index advances by one on each clock with `sample_en` high and wraps from 999 to 0, so the carrier repeats every 1000 enabled samples.
- R3: With the strong amplitude selected, the word for phase index p is 2048 + round(2047·sin(2πp/1000)), rounded away from zero (4095 at p = 250, 1 at p = 750).
- R4: With the weak amplitude selected, the word for phase index p is 2048 + round(614·sin(2πp/1000)), so it never leaves 1434..2662.
- R5: The amplitude for a whole carrier cycle is taken from `level_in` (1 = strong, 0 = weak) on the enabled clock at phase index 0. Changes of `level_in` at any other phase have no effect on the words of that cycle.
- R6: After a clock with `sample_en` high, `dac_wr` is high for exactly the following cycle and `sample_out` carries the word for the phase index that clock consumed.
- R7: After a clock with `sample_en` low, `dac_wr` is low and `sample_out` keeps its previous value.
- R8: A baseband pulse held for the first n carrier cycles of a ten-cycle symbol (n = 2, 5 or 8) yields exactly n strong cycles among the ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample-rate enable; one output word per high cycle |
| level_in | input | 1 | Baseband code level; 1 requests the strong amplitude |
| sample_out | output | 12 | Unsigned offset-binary sample, centred on 2048 |
| dac_wr | output | 1 | Write strobe; high for one cycle when `sample_out` holds a new word |

## Verification
Every result of this block is due exactly one clock after the enabled edge that produced it. The strobe, the new word and the amplitude latched at phase 0 all appear in that cycle, and a disabled edge shows its held word and low strobe one clock later. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is one full register stage after the rising edge that consumed them. Its reference model advances its phase and amplitude choice only on enabled samples, so gaps in the enable do not shift what it expects.

// File: rtl/askg_pkg.sv
package askg_pkg;

  // Rounded magnitude of amp*sin(2*pi*idx/period) for a first-quarter index.
  function automatic int sine_mag(int idx, int amp, int period);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(period);
    v   = real'(amp) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/askg_phase_ctr.sv
module askg_phase_ctr #(
  parameter int PHASES = 1000,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          level,
  output logic [PW-1:0] phase_o,
  output logic          sel_o,
  output logic          hi_q_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;
  logic          hi_q;

  // amplitude is re-decided only at the start of a carrier cycle
  assign sel_o   = (phase_q == '0) ? level : hi_q;
  assign phase_o = phase_q;
  assign hi_q_o  = hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      hi_q    <= 1'b0;
    end else if (step) begin
      hi_q    <= sel_o;
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/askg_quarter_rom.sv
module askg_quarter_rom
  import askg_pkg::*;
#(
  parameter int PHASES = 1000,
  parameter int PW     = $clog2(PHASES),
  parameter int DW     = 12,
  parameter int AMP_HI = 2047,
  parameter int AMP_LO = 614
) (
  input  logic [PW-1:0] phase,
  input  logic          hi,
  output logic [DW-1:0] word
);
  localparam int QTR = PHASES / 4;
  localparam int HALF = PHASES / 2;
  localparam int QW = $clog2(QTR + 1);
  localparam logic [PW-1:0] HALF_P = PW'(HALF);
  localparam logic [PW-1:0] QTR_P = PW'(QTR);
  localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

  logic [DW-1:0] hi_tab [QTR+1];
  logic [DW-1:0] lo_tab [QTR+1];

  for (genvar i = 0; i <= QTR; i++) begin : g_tab
    assign hi_tab[i] = DW'(sine_mag(i, AMP_HI, PHASES));
    assign lo_tab[i] = DW'(sine_mag(i, AMP_LO, PHASES));
  end

  logic          neg;
  logic [PW-1:0] off;
  logic [PW-1:0] fold;
  logic [QW-1:0] idx;
  logic [DW-1:0] mag;

  always_comb begin
    neg  = (phase >= HALF_P);
    off  = neg ? phase - HALF_P : phase;
    fold = (off <= QTR_P) ? off : HALF_P - off;
    idx  = QW'(fold);
    mag  = hi ? hi_tab[idx] : lo_tab[idx];
    word = neg ? MID - mag : MID + mag;
  end
endmodule

// File: rtl/askg_sample_reg.sv
module askg_sample_reg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] sample_o,
  output logic          wr_o
);
  localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= MID;
      wr_o     <= 1'b0;
    end else begin
      wr_o <= load;
      if (load) sample_o <= word_in;
    end
  end
endmodule

// File: rtl/amp_keyed_sine_gen.sv
module amp_keyed_sine_gen #(
  parameter int PHASES = 1000,
  parameter int DW     = 12,
  parameter int AMP_HI = 2047,
  parameter int AMP_LO = 614
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          level_in,
  output logic [DW-1:0] sample_out,
  output logic          dac_wr
);
  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] phase_q;
  logic          sel_now;
  logic          hi_sel_q;
  logic [DW-1:0] word;

  askg_phase_ctr #(.PHASES(PHASES), .PW(PW)) phase_i (
    .clk(clk), .rst(rst), .step(sample_en), .level(level_in),
    .phase_o(phase_q), .sel_o(sel_now), .hi_q_o(hi_sel_q)
  );

  askg_quarter_rom #(.PHASES(PHASES), .PW(PW), .DW(DW),
                     .AMP_HI(AMP_HI), .AMP_LO(AMP_LO)) rom_i (
    .phase(phase_q), .hi(sel_now), .word(word)
  );

  askg_sample_reg #(.DW(DW)) out_i (
    .clk(clk), .rst(rst), .load(sample_en), .word_in(word),
    .sample_o(sample_out), .wr_o(dac_wr)
  );
endmodule

// File: rtl/askg_chk.sv
module askg_chk #(
  parameter int PHASES = 1000,
  parameter int DW     = 12,
  parameter int AMP_LO = 614,
  parameter int PW     = $clog2(PHASES)
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_en,
  input logic [DW-1:0] sample_out,
  input logic          dac_wr,
  input logic [PW-1:0] phase,
  input logic          hi_sel
);
  localparam int MID = 1 << (DW - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (int'(sample_out) == MID && !dac_wr && phase == '0 && !hi_sel));

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && int'(phase) == PHASES - 1) |=> (phase == '0));

  // R4
  low_range_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_wr && !hi_sel) |-> (int'(sample_out) >= MID - AMP_LO && int'(sample_out) <= MID + AMP_LO));

  // R5
  region_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_en && phase != '0) |=> $stable(hi_sel));

  // R6
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> dac_wr);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> (!dac_wr && $stable(sample_out)));
endmodule

bind amp_keyed_sine_gen askg_chk #(.PHASES(PHASES), .DW(DW), .AMP_LO(AMP_LO)) chk_i (
  .clk(clk), .rst(rst), .sample_en(sample_en), .sample_out(sample_out),
  .dac_wr(dac_wr), .phase(phase_q), .hi_sel(hi_sel_q)
);

// File: tb/amp_keyed_sine_gen_tb_top.sv
module amp_keyed_sine_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_en = 1'b0;
  logic        level_in = 1'b0;
  logic [11:0] sample_out;
  logic        dac_wr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // model state
  int mph = 0;
  bit msel = 0;
  int last_word = 2048;
  int strong_cyc = 0;

  // stimulus vectors: {strong carrier cycles, enable stride}
  localparam int VEC [4][2] = '{'{2, 1}, '{5, 1}, '{8, 1}, '{5, 2}};

  always #10 clk = ~clk;

  amp_keyed_sine_gen dut_i (
    .clk(clk), .rst(rst), .sample_en(sample_en), .level_in(level_in),
    .sample_out(sample_out), .dac_wr(dac_wr)
  );

  function automatic int exp_word(int p, bit hi);
    real v;
    int  r;
    v = (hi ? 2047.0 : 614.0) * $sin(2.0 * 3.14159265358979323846 * real'(p) / 1000.0);
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    return 2048 + r;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // drive at a falling edge, check one register stage later
  task automatic do_sample(bit lvl, bit en);
    int e;
    sample_en = en;
    level_in  = lvl;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      if (mph == 0) msel = lvl;
      e = exp_word(mph, msel);
      if (mph == 250 && msel) strong_cyc++;
      mph = (mph + 1) % 1000;
      last_word = e;
      chk(dac_wr == 1'b1, "R6 strobe", int'(dac_wr), 1);
      chk(int'(sample_out) == e, msel ? "R3 strong word" : "R4 weak word", int'(sample_out), e);
    end else begin
      chk(dac_wr == 1'b0, "R7 strobe idle", int'(dac_wr), 0);
      chk(int'(sample_out) == last_word, "R7 hold", int'(sample_out), last_word);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sample_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(int'(sample_out) == 2048, "R1 reset word", int'(sample_out), 2048);
    chk(dac_wr == 1'b0, "R1 reset strobe", int'(dac_wr), 0);
    rst = 1'b0;
    mph = 0;
    msel = 0;
    last_word = 2048;
  endtask

  function automatic void finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // vector walk: one ten-cycle symbol per entry (R8)
    for (int v = 0; v < 4; v++) begin
      strong_cyc = 0;
      for (int c = 0; c < 10; c++) begin
        for (int s = 0; s < 1000; s++) begin
          do_sample(c < VEC[v][0], 1'b1);
          if (VEC[v][1] == 2) do_sample(c < VEC[v][0], 1'b0);
        end
      end
      chk(strong_cyc == VEC[v][0], "R8 strong cycles", strong_cyc, VEC[v][0]);
    end

    // R2: phase wraps after 1000 samples, the next word is mid-scale
    chk(mph == 0, "R2 model wrap", mph, 0);
    do_sample(1'b1, 1'b1);
    chk(int'(sample_out) == 2048, "R2 wrap word", int'(sample_out), 2048);
    for (int s = 1; s < 1000; s++) do_sample(1'b0, 1'b1);

    // R5: level rises mid-cycle, weak cycle must stay weak
    strong_cyc = 0;
    for (int s = 0; s < 1000; s++) do_sample(s >= 100, 1'b1);
    chk(strong_cyc == 0, "R5 mid-cycle rise ignored", strong_cyc, 0);
    // R5: level high only at phase 0 -> whole cycle strong
    for (int s = 0; s < 1000; s++) do_sample(s == 0, 1'b1);
    chk(strong_cyc == 1, "R5 phase-0 decides", strong_cyc, 1);
    chk(int'(sample_out) == exp_word(999, 1'b1), "R3 last strong point", int'(sample_out), exp_word(999, 1'b1));

    // R1: reset in the middle of a strong cycle
    for (int s = 0; s < 300; s++) do_sample(1'b1, 1'b1);
    do_reset();
    do_sample(1'b1, 1'b1);
    chk(int'(sample_out) == 2048, "R1 restart at phase 0", int'(sample_out), 2048);
    do_sample(1'b0, 1'b1);
    chk(int'(sample_out) == 2061, "R1 restart strong step", int'(sample_out), 2061);
    do_sample(1'b0, 1'b0);
    do_sample(1'b0, 1'b0);

    finish_run();
  end
endmodule